// File: doc/BRIEF.md
# Bus Access Counting Peripheral

This block is a small memory-mapped test peripheral that lets CPU test software confirm that each instruction issues exactly the reads and writes it should on the external data bus. It decodes eight consecutive word offsets. Two of them are plain scratch registers the CPU can load and read back. Four of them hold per-register, per-direction access counters. The remaining two are reserved. Test code clears or presets the counters, runs an instruction sequence that touches the scratch registers, and then reads the counters to compare them against the expected access pattern.

The bus is synchronous. The CPU presents the offset and a read or write indication together with a device select. Read data is driven combinationally, so it is valid before the next rising edge. A CPU can hold one access over several clocks, either because of its own sequencing or because this block asks for wait states. The block therefore counts an access once, when a qualified strobe first appears. It arms itself again only when the select drops, the offset changes or the direction changes. This keeps stretched accesses from being counted more than once, while back-to-back accesses that really are distinct are still each counted.

Top module: `bus_probe_counter`

## Requirements
- R1: After reset, the scratch registers and all four counters read as zero, and `wait_o` is low.
- R2: A write to offset 0 or offset 1 stores `wdata_i` in that scratch register. Reading that offset returns the stored value on `rdata_o` in the same cycle the offset is presented.
- R3: Offsets 2 and 3 always read as zero. Writes to them change neither scratch register nor any counter.
- R4: Each counted read of offset 0 adds one to the counter at offset 4. Each counted read of offset 1 adds one to the counter at offset 5. The new value is readable from the cycle after the access starts.
- R5: Each counted write to offset 0 adds one to the counter at offset 6. Each counted write to offset 1 adds one to the counter at offset 7.
- R6: An access held with unchanged select, offset and direction for several consecutive cycles is counted exactly once, including any cycles spent in wait states.
- R7: A new count is taken whenever the qualified strobe (select with read or write) reappears after select drops, or while held with a different offset or a different direction.
- R8: Writing offset 4, 5, 6 or 7 loads that counter with `wdata_i`, and the load takes priority over a counted event in the same cycle. Reads and writes of offsets 4 to 7 never change any counter except the one written.
- R9: Counters are 16 bits wide and wrap from 0xFFFF to 0x0000.
- R10: With WAIT_STATES = N > 0, `wait_o` is high for the first N cycles of each newly counted access and low otherwise. It is always low when no access is strobed.
- R11: When read and write are both asserted with select, the access is treated as a write, both for storage and for counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Device select from the address decoder |
| rd_i | input | 1 | Read indication |
| wr_i | input | 1 | Write indication |
| addr_i | input | 3 | Word offset within the window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the presented offset (combinational) |
| wait_o | output | 1 | Wait request to the CPU |

## Verification
The bench builds the block with WAIT_STATES = 2. With that value, every fresh access holds `wait_o` over two cycles, so the check that stalled cycles add no extra count covers a real multi-cycle stall and not a single-cycle pulse. The data width is kept at 16, which means the wrap test only has to preload 0xFFFF through the normal counter write and then make one counted access. The same build also covers held accesses of three and four cycles and back-to-back accesses that differ only in offset or only in direction.

// File: rtl/bpc_pkg.sv
// Package: shared offsets and sizes for the bus access counting peripheral.
// Assumes a fixed eight-word window; only the offsets below carry meaning.
package bpc_pkg;
    localparam int unsigned OFS_W      = 3;
    localparam int unsigned NUM_SCR    = 2;
    localparam int unsigned NUM_CNT    = 4;

    localparam logic [OFS_W-1:0] OFS_SCR0   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_SCR1   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CNT_LO = 3'd4;

    // Counter slot order: read of scratch 0, read of scratch 1,
    // write of scratch 0, write of scratch 1 (offsets 4..7).
    typedef enum logic [1:0] {
        SLOT_RD0 = 2'd0,
        SLOT_RD1 = 2'd1,
        SLOT_WR0 = 2'd2,
        SLOT_WR1 = 2'd3
    } cnt_slot_e;
endpackage

// File: rtl/bpc_access_detect.sv
// Module: bpc_access_detect
// Turns the multi-cycle bus strobe into one-cycle "access start" pulses.
// Assumes: a write indication wins over a read indication when both are high.
// An access re-arms when select drops, the offset changes or direction changes.
module bpc_access_detect #(
    parameter int unsigned OFS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [OFS_W-1:0] addr_i,
    output logic             act_o,
    output logic             is_wr_o,
    output logic             start_o
);
    logic             prev_act_q;
    logic             prev_wr_q;
    logic [OFS_W-1:0] prev_addr_q;

    // Purpose: qualify the strobe and decide whether it opens a new access.
    always_comb begin
        act_o   = sel_i & (rd_i | wr_i);
        is_wr_o = wr_i;
        start_o = act_o & (~prev_act_q | (addr_i != prev_addr_q) | (is_wr_o != prev_wr_q));
    end

    // Purpose: remember the previous cycle's strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_act_q  <= 1'b0;
            prev_wr_q   <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_act_q  <= act_o;
            prev_wr_q   <= is_wr_o;
            prev_addr_q <= addr_i;
        end
    end
endmodule

// File: rtl/bpc_wait_gen.sv
// Module: bpc_wait_gen
// Requests WAIT_STATES stall cycles at the start of each counted access.
// Assumes start_i pulses for one cycle on the first cycle of an access.
// WAIT_STATES = 0 removes the request entirely.
module bpc_wait_gen #(
    parameter int unsigned WAIT_STATES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic act_i,
    output logic wait_o
);
    generate
        if (WAIT_STATES == 0) begin : g_none
            assign wait_o = 1'b0;
        end else if (WAIT_STATES == 1) begin : g_single
            assign wait_o = start_i;
        end else begin : g_multi
            localparam int unsigned WC_W = $clog2(WAIT_STATES);
            localparam logic [WC_W-1:0] WC_INIT = WC_W'(WAIT_STATES - 1);
            logic [WC_W-1:0] left_q;

            // Purpose: stall on the start cycle and while stall cycles remain.
            assign wait_o = start_i | (act_i & (left_q != '0));

            // Purpose: count down the remaining stall cycles of the access.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left_q <= '0;
                end else if (start_i) begin
                    left_q <= WC_INIT;
                end else if (!act_i) begin
                    left_q <= '0;
                end else if (left_q != '0) begin
                    left_q <= left_q - 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bpc_counter_bank.sv
// Module: bpc_counter_bank
// A bank of wrapping event counters, each with a software load port.
// Assumes: a load and an increment in the same cycle resolve to the load.
module bpc_counter_bank #(
    parameter int unsigned NUM   = 4,
    parameter int unsigned CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            ld_i,
    input  logic [NUM-1:0]            inc_i,
    input  logic [CNT_W-1:0]          ld_val_i,
    output logic [NUM-1:0][CNT_W-1:0] cnt_o
);
    generate
        for (genvar i = 0; i < NUM; i++) begin : g_cnt
            logic [CNT_W-1:0] val_q;

            // Purpose: load from software, else count one event, wrapping.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (ld_i[i]) begin
                    val_q <= ld_val_i;
                end else if (inc_i[i]) begin
                    val_q <= val_q + 1'b1;
                end
            end

            assign cnt_o[i] = val_q;
        end
    endgenerate
endmodule

// File: rtl/bus_probe_counter.sv
// Module: bus_probe_counter (top)
// Eight-word test peripheral: two scratch registers, two reserved words and
// four access counters (reads of scratch 0/1, writes of scratch 0/1).
// Assumes the address decoder drives sel_i only for this window and that
// read data is sampled by the CPU at the edge after the offset is presented.
module bus_probe_counter #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned WAIT_STATES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              wait_o
);
    import bpc_pkg::*;

    logic                              act, is_wr, start;
    logic [NUM_SCR-1:0][DATA_W-1:0]    scr_q;
    logic [NUM_CNT-1:0][DATA_W-1:0]    cnt_q;
    logic [NUM_CNT-1:0]                cnt_ld, cnt_inc;
    logic [NUM_SCR-1:0]                scr_we;

    bpc_access_detect #(.OFS_W(OFS_W)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_i),
        .rd_i    (rd_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .act_o   (act),
        .is_wr_o (is_wr),
        .start_o (start)
    );

    bpc_wait_gen #(.WAIT_STATES(WAIT_STATES)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .act_i   (act),
        .wait_o  (wait_o)
    );

    // Purpose: decode scratch writes, counter loads and counted events.
    always_comb begin
        for (int i = 0; i < NUM_SCR; i++) begin
            scr_we[i] = act & is_wr & (addr_i == OFS_SCR0 + OFS_W'(i));
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            cnt_ld[i] = act & is_wr & (addr_i == OFS_CNT_LO + OFS_W'(i));
        end
        cnt_inc           = '0;
        cnt_inc[SLOT_RD0] = start & ~is_wr & (addr_i == OFS_SCR0);
        cnt_inc[SLOT_RD1] = start & ~is_wr & (addr_i == OFS_SCR1);
        cnt_inc[SLOT_WR0] = start &  is_wr & (addr_i == OFS_SCR0);
        cnt_inc[SLOT_WR1] = start &  is_wr & (addr_i == OFS_SCR1);
    end

    generate
        for (genvar s = 0; s < NUM_SCR; s++) begin : g_scr
            // Purpose: hold one scratch word, updated on every write cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scr_q[s] <= '0;
                end else if (scr_we[s]) begin
                    scr_q[s] <= wdata_i;
                end
            end
        end
    endgenerate

    bpc_counter_bank #(.NUM(NUM_CNT), .CNT_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (cnt_ld),
        .inc_i    (cnt_inc),
        .ld_val_i (wdata_i),
        .cnt_o    (cnt_q)
    );

    // Purpose: combinational read mux; reserved offsets return zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i[2]) begin
            rdata_o = cnt_q[addr_i[1:0]];
        end else if (addr_i[1] == 1'b0) begin
            rdata_o = scr_q[addr_i[0]];
        end
    end
endmodule

// File: rtl/bpc_checker.sv
// Module: bpc_checker
// Temporal checks for bus_probe_counter, attached by bind below.
// Assumes the synchronous active-low reset of the checked block.
module bpc_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sel_i,
    input logic                   rd_i,
    input logic                   wr_i,
    input logic [2:0]             addr_i,
    input logic [DATA_W-1:0]      wdata_i,
    input logic [DATA_W-1:0]      rdata_o,
    input logic                   wait_o,
    input logic [3:0][DATA_W-1:0] cnt_q,
    input logic [1:0][DATA_W-1:0] scr_q
);
    logic rd0_now;
    assign rd0_now = sel_i & rd_i & ~wr_i & (addr_i == 3'd0);

    // R10: no stall request without a strobed access.
    p_wait_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i & (rd_i | wr_i)) |-> !wait_o);

    // R3: reserved offsets read as zero.
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 3'd2 || addr_i == 3'd3) |-> (rdata_o == '0));

    // R6: a read of offset 0 held from the previous cycle adds nothing.
    p_held_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_now && $past(rd0_now) && $past(rst_n)) |=> $stable(cnt_q[0]));

    // R4: without a load the read-0 counter moves by zero or one.
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i & wr_i & (addr_i == 3'd4)) |=>
        (cnt_q[0] == $past(cnt_q[0]) || cnt_q[0] == DATA_W'($past(cnt_q[0]) + 1'b1)));

    // R8: a software write to offset 4 loads the counter.
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i & wr_i & (addr_i == 3'd4)) |=> (cnt_q[0] == $past(wdata_i)));

    // R2: scratch 0 only changes through a write to offset 0.
    p_scratch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i & wr_i & (addr_i == 3'd0)) |=> $stable(scr_q[0]));
endmodule

bind bus_probe_counter bpc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .wait_o  (wait_o),
    .cnt_q   (cnt_q),
    .scr_q   (scr_q)
);

// File: tb/tb_bus_probe_counter.sv
// Directed bench for bus_probe_counter: one task per scenario.
module tb_bus_probe_counter;
    localparam int CLK_PERIOD = 10;
    localparam int WS         = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        wait_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_probe_counter #(.DATA_W(16), .WAIT_STATES(WS)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wait_o(wait_o)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic s, input logic r, input logic w,
                         input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = s; rd = r; wr = w; addr = a; wdata = d;
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 3'd0, 16'h0);
        hold(1);
    endtask

    task automatic acc(input bit w, input logic [2:0] a, input logic [15:0] d, input int n);
        drive(1'b1, ~w, w, a, d);
        hold(n);
    endtask

    task automatic rd_val(input logic [2:0] a, output logic [15:0] v);
        drive(1'b1, 1'b1, 1'b0, a, 16'h0);
        #1 v = rdata;
        hold(1);
    endtask

    task automatic clear_cnt();
        for (int i = 4; i < 8; i++) acc(1'b1, 3'(i), 16'h0, 1);
        idle();
    endtask

    task automatic check_cnts(input string tag, input logic [15:0] e4, input logic [15:0] e5,
                              input logic [15:0] e6, input logic [15:0] e7);
        logic [15:0] v;
        rd_val(3'd4, v); check({tag, " cnt4"}, v, e4);
        rd_val(3'd5, v); check({tag, " cnt5"}, v, e5);
        rd_val(3'd6, v); check({tag, " cnt6"}, v, e6);
        rd_val(3'd7, v); check({tag, " cnt7"}, v, e7);
        idle();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        #1 check("R1 wait after reset", {15'h0, wait_o}, 16'h0);
        check_cnts("R1", 16'h0, 16'h0, 16'h0, 16'h0);
        rd_val(3'd0, v); check("R1 scratch0", v, 16'h0);
        idle();
        rd_val(3'd1, v); check("R1 scratch1", v, 16'h0);
        idle();
    endtask

    task automatic t_scratch();
        logic [15:0] v;
        acc(1'b1, 3'd0, 16'hA5A5, 1);
        acc(1'b1, 3'd1, 16'h5A5A, 1);
        idle();
        rd_val(3'd0, v); check("R2 scratch0", v, 16'hA5A5);
        rd_val(3'd1, v); check("R2 scratch1", v, 16'h5A5A);
        idle();
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        clear_cnt();
        acc(1'b1, 3'd2, 16'h1234, 1);
        acc(1'b1, 3'd3, 16'h4321, 1);
        idle();
        rd_val(3'd2, v); check("R3 ofs2", v, 16'h0);
        rd_val(3'd3, v); check("R3 ofs3", v, 16'h0);
        idle();
        check_cnts("R3", 16'h0, 16'h0, 16'h0, 16'h0);
        rd_val(3'd0, v); check("R3 scratch0 kept", v, 16'hA5A5);
        rd_val(3'd1, v); check("R3 scratch1 kept", v, 16'h5A5A);
        idle();
    endtask

    task automatic t_count();
        clear_cnt();
        acc(1'b0, 3'd0, 16'h0, 1); idle();
        acc(1'b0, 3'd1, 16'h0, 1); idle();
        acc(1'b0, 3'd1, 16'h0, 1); idle();
        for (int i = 0; i < 3; i++) begin
            acc(1'b1, 3'd0, 16'(i), 1); idle();
        end
        check_cnts("R4 R5 single", 16'd1, 16'd2, 16'd3, 16'd0);
        acc(1'b1, 3'd1, 16'h9, 1); idle();
        check_cnts("R5 wr1", 16'd1, 16'd2, 16'd3, 16'd1);
    endtask

    task automatic t_hold();
        clear_cnt();
        acc(1'b0, 3'd0, 16'h0, 3); idle();
        acc(1'b1, 3'd1, 16'hBEEF, 4); idle();
        check_cnts("R6 held", 16'd1, 16'd0, 16'd0, 16'd1);
    endtask

    task automatic t_rearm();
        clear_cnt();
        acc(1'b0, 3'd0, 16'h0, 1);
        acc(1'b0, 3'd1, 16'h0, 1);
        acc(1'b0, 3'd0, 16'h0, 1);
        acc(1'b1, 3'd0, 16'h77, 1);
        idle();
        acc(1'b1, 3'd0, 16'h78, 1);
        idle();
        check_cnts("R7 rearm", 16'd2, 16'd1, 16'd2, 16'd0);
    endtask

    task automatic t_counter_rw();
        logic [15:0] v;
        clear_cnt();
        acc(1'b1, 3'd5, 16'h0042, 1);
        acc(1'b1, 3'd7, 16'h1001, 3);
        idle();
        rd_val(3'd5, v); check("R8 load5", v, 16'h0042);
        rd_val(3'd5, v); check("R8 reread5", v, 16'h0042);
        idle();
        check_cnts("R8 others", 16'd0, 16'h0042, 16'd0, 16'h1001);
    endtask

    task automatic t_wrap();
        clear_cnt();
        acc(1'b1, 3'd4, 16'hFFFF, 1); idle();
        acc(1'b0, 3'd0, 16'h0, 1); idle();
        check_cnts("R9 wrap", 16'h0000, 16'd0, 16'd0, 16'd0);
    endtask

    task automatic t_both();
        logic [15:0] v;
        clear_cnt();
        drive(1'b1, 1'b1, 1'b1, 3'd1, 16'h7777);
        hold(1);
        idle();
        check_cnts("R11 both", 16'd0, 16'd0, 16'd0, 16'd1);
        rd_val(3'd1, v); check("R11 stored", v, 16'h7777);
        idle();
    endtask

    task automatic t_wait();
        clear_cnt();
        #1 check("R10 idle wait", {15'h0, wait_o}, 16'h0);
        drive(1'b1, 1'b1, 1'b0, 3'd0, 16'h0);
        #1 check("R10 wait cyc0", {15'h0, wait_o}, 16'h1);
        hold(1);
        @(negedge clk);
        #1 check("R10 wait cyc1", {15'h0, wait_o}, 16'h1);
        hold(1);
        @(negedge clk);
        #1 check("R10 wait cyc2", {15'h0, wait_o}, 16'h0);
        hold(1);
        idle();
        check_cnts("R10 R6 stalled", 16'd1, 16'd0, 16'd0, 16'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_scratch();
        t_reserved();
        t_count();
        t_hold();
        t_rearm();
        t_counter_rw();
        t_wrap();
        t_both();
        t_wait();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule